// File: doc/BRIEF.md
# Leaky Integrate-and-Fire Neuron with Stepped Threshold Homeostasis

This block is one digital spiking neuron. Each clock cycle is one time step. On every step it adds a signed synaptic contribution to its membrane value and lets the membrane leak toward zero. When the result rises strictly above the current firing threshold, the neuron emits a one-cycle spike. The membrane then returns to the reset level and stays there for a fixed refractory window, during which all input is ignored.

The firing threshold is not continuously tuned. It is picked from a small parameter table of preset levels by a level index. That index can move by one position only in a cycle in which the neuron fires. The direction of the move comes from an activity trace. The trace jumps up by a fixed amount on each spike and decays by a shift between spikes. It is compared against a target band. Two learning thresholds, one for potentiation and one for depression, sit at fixed offsets below the firing threshold. They therefore move with it by the same step and keep their ordering. All three thresholds are driven out for the neighbouring plasticity logic. A two-entry table gives a binary threshold.

Top module: `lif_homeo_neuron`

## Requirements
- R1: While `rst` is high, `spike` is 0, `membrane` is 0 (the reset level), `activity` is 0, `level` equals `INIT_LVL`, and the three thresholds correspond to that level.
- R2: Outside the refractory window, the next membrane value is `m - (m >>> LEAK_SH) + syn_in`, computed with arithmetic shift and full precision. When that value does not exceed `thr_fire`, it is what `membrane` shows after the clock edge.
- R3: When that next value is strictly greater than `thr_fire`, `spike` is 1 for exactly one cycle and `membrane` shows 0. A value equal to the threshold does not fire.
- R4: For the `REFRAC` cycles that follow a spike, `membrane` stays 0 and `spike` stays 0, whatever `syn_in` carries.
- R5: Each cycle, `activity` becomes `a - (a >> TR_SH)`, where `a` is its previous value. In a spike cycle, `TR_INC` is added on top of that.
- R6: In a spike cycle, `level` rises by one when the pre-update `activity` is above `TARGET + MARGIN`. It falls by one when `activity` is below `TARGET - MARGIN`. Otherwise it holds. In a cycle without a spike, `level` never changes.
- R7: `level` saturates: it stays at `NUM_LEVELS-1` when asked to rise there, and stays at 0 when asked to fall there.
- R8: `thr_fire` is table entry `level` (entry 0 in the least significant `MEM_W` bits of `FIRE_LVLS`). `thr_pot` is `thr_fire - POT_GAP`, and `thr_dep` is `thr_fire - DEP_GAP`, so `thr_dep < thr_pot < thr_fire`.
- R9: With `NUM_LEVELS = 2`, the same rules give a binary threshold that toggles between its two entries.
- R10: The membrane sum saturates to the signed `MEM_W` range instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge per time step |
| rst | input | 1 | Synchronous active-high reset |
| syn_in | input | MEM_W | Signed summed synaptic input for this step |
| spike | output | 1 | One-cycle output spike |
| membrane | output | MEM_W | Signed membrane value |
| activity | output | TR_W | Activity trace |
| level | output | IDX_W | Current threshold table index |
| thr_fire | output | MEM_W | Signed firing threshold |
| thr_pot | output | MEM_W | Signed potentiation threshold |
| thr_dep | output | MEM_W | Signed depression threshold |

## Verification
The bench feeds a cycle-accurate model and two neurons in parallel: a four-level one and a binary one. It first drives an input that lands exactly on the threshold. A design that fired on equality would spike there. Full-scale negative inputs are stacked so that a wrapping adder would turn the membrane large and positive and cause a spike. Dense bursts pin the index at the top and sparse lone spikes pin it at the bottom. A design that wraps the index would jump to the opposite end. Trains with a seven-cycle period put the trace inside the dead band, and large inputs placed inside the refractory window would leak into the membrane if the hold were short.

// File: rtl/lifh_pkg.sv
package lifh_pkg;
  typedef enum logic [1:0] {
    LVL_HOLD  = 2'd0,
    LVL_RAISE = 2'd1,
    LVL_LOWER = 2'd2
  } lvl_move_e;
endpackage

// File: rtl/lifh_membrane.sv
module lifh_membrane #(
  parameter int MEM_W   = 16,
  parameter int LEAK_SH = 3,
  parameter int REFRAC  = 3,
  parameter logic signed [MEM_W-1:0] RST_LVL = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [MEM_W-1:0] syn_in,
  input  logic signed [MEM_W-1:0] thr_fire,
  output logic                    fire_now,
  output logic                    spike,
  output logic signed [MEM_W-1:0] mem
);
  localparam int CNT_W = $clog2(REFRAC + 1);
  localparam int EXT_W = MEM_W + 2;
  localparam logic signed [EXT_W-1:0] V_MAX = {3'b000, {(MEM_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] V_MIN = {3'b111, {(MEM_W-1){1'b0}}};

  logic signed [MEM_W-1:0] v_q;
  logic signed [MEM_W-1:0] leak_w;
  logic signed [MEM_W-1:0] v_sat;
  logic signed [EXT_W-1:0] sum_w;
  logic [CNT_W-1:0]        ref_q;
  logic                    spike_q;

  // leak, integrate, clamp; fire only outside the refractory window
  always_comb begin
    leak_w = v_q >>> LEAK_SH;
    sum_w  = {{2{v_q[MEM_W-1]}}, v_q}
           - {{2{leak_w[MEM_W-1]}}, leak_w}
           + {{2{syn_in[MEM_W-1]}}, syn_in};
    if (sum_w > V_MAX)      v_sat = V_MAX[MEM_W-1:0];
    else if (sum_w < V_MIN) v_sat = V_MIN[MEM_W-1:0];
    else                    v_sat = sum_w[MEM_W-1:0];
    fire_now = (ref_q == '0) && (v_sat > thr_fire);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q     <= RST_LVL;
      ref_q   <= '0;
      spike_q <= 1'b0;
    end else begin
      spike_q <= fire_now;
      if (ref_q != '0) begin
        ref_q <= ref_q - 1'b1;
        v_q   <= RST_LVL;
      end else if (fire_now) begin
        ref_q <= CNT_W'(REFRAC);
        v_q   <= RST_LVL;
      end else begin
        v_q   <= v_sat;
      end
    end
  end

  assign spike = spike_q;
  assign mem   = v_q;

  // R3: a spike lasts one cycle and leaves the membrane at reset
  p_spike_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    spike |=> !spike);
  p_spike_reset_r3: assert property (@(posedge clk) disable iff (rst)
    spike |-> (mem == RST_LVL));
  // R4: the cycle after a spike is still held at reset
  p_refrac_hold_r4: assert property (@(posedge clk) disable iff (rst)
    spike |=> (mem == RST_LVL));
endmodule

// File: rtl/lifh_trace.sv
module lifh_trace #(
  parameter int TR_W   = 12,
  parameter int TR_SH  = 4,
  parameter int TR_INC = 256
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire_now,
  output logic [TR_W-1:0] act
);
  localparam logic [TR_W:0] INC_X = (TR_W+1)'(TR_INC);

  logic [TR_W-1:0] tr_q;
  logic [TR_W-1:0] dec_w;
  logic [TR_W:0]   sum_w;
  logic [TR_W-1:0] nxt_w;

  always_comb begin
    dec_w = tr_q - (tr_q >> TR_SH);
    sum_w = {1'b0, dec_w} + INC_X;
    if (fire_now) nxt_w = sum_w[TR_W] ? {TR_W{1'b1}} : sum_w[TR_W-1:0];
    else          nxt_w = dec_w;
  end

  always_ff @(posedge clk) begin
    if (rst) tr_q <= '0;
    else     tr_q <= nxt_w;
  end

  assign act = tr_q;

  // R5: without a spike the trace can only decay
  p_trace_decay_r5: assert property (@(posedge clk) disable iff (rst)
    !fire_now |=> (act <= $past(act)));
endmodule

// File: rtl/lifh_thresh.sv
module lifh_thresh
  import lifh_pkg::*;
#(
  parameter int NUM_LEVELS = 4,
  parameter int MEM_W      = 16,
  parameter logic [NUM_LEVELS*MEM_W-1:0] FIRE_LVLS = '0,
  parameter int POT_GAP    = 40,
  parameter int DEP_GAP    = 80,
  parameter int INIT_LVL   = 0,
  parameter int TR_W       = 12,
  parameter int TARGET     = 512,
  parameter int MARGIN     = 128,
  localparam int IDX_W     = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fire_now,
  input  logic [TR_W-1:0]         act,
  output logic [IDX_W-1:0]        level,
  output logic signed [MEM_W-1:0] thr_fire,
  output logic signed [MEM_W-1:0] thr_pot,
  output logic signed [MEM_W-1:0] thr_dep
);
  localparam int HI_BAND = TARGET + MARGIN;
  localparam int LO_BAND = TARGET - MARGIN;
  localparam logic [IDX_W-1:0] TOP  = IDX_W'(NUM_LEVELS - 1);
  localparam logic [IDX_W-1:0] INIT = IDX_W'(INIT_LVL);
  localparam logic signed [MEM_W-1:0] POT_D = MEM_W'(POT_GAP);
  localparam logic signed [MEM_W-1:0] DEP_D = MEM_W'(DEP_GAP);

  logic signed [MEM_W-1:0] lvl_tab [NUM_LEVELS];
  logic [IDX_W-1:0]        idx_q;
  logic [IDX_W-1:0]        idx_nxt;
  lvl_move_e               move;
  int                      act_i;

  genvar g;
  generate
    for (g = 0; g < NUM_LEVELS; g++) begin : g_lvl
      assign lvl_tab[g] = FIRE_LVLS[g*MEM_W +: MEM_W];
    end
  endgenerate

  always_comb begin
    act_i = int'(act);
    move  = LVL_HOLD;
    if (fire_now) begin
      if (act_i > HI_BAND && idx_q != TOP)      move = LVL_RAISE;
      else if (act_i < LO_BAND && idx_q != '0)  move = LVL_LOWER;
    end
    case (move)
      LVL_RAISE: idx_nxt = idx_q + 1'b1;
      LVL_LOWER: idx_nxt = idx_q - 1'b1;
      default:   idx_nxt = idx_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= INIT;
      thr_fire <= lvl_tab[INIT];
      thr_pot  <= lvl_tab[INIT] - POT_D;
      thr_dep  <= lvl_tab[INIT] - DEP_D;
    end else begin
      idx_q    <= idx_nxt;
      thr_fire <= lvl_tab[idx_nxt];
      thr_pot  <= lvl_tab[idx_nxt] - POT_D;
      thr_dep  <= lvl_tab[idx_nxt] - DEP_D;
    end
  end

  assign level = idx_q;

  // R6: the index is frozen in steps without a spike
  p_idx_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !fire_now |=> $stable(idx_q));
  // R7: the index never leaves the table
  p_idx_range_r7: assert property (@(posedge clk) disable iff (rst)
    idx_q <= TOP);
  // R8: learning thresholds keep their order under the firing threshold
  p_thr_order_r8: assert property (@(posedge clk) disable iff (rst)
    (thr_dep < thr_pot) && (thr_pot < thr_fire));
endmodule

// File: rtl/lif_homeo_neuron.sv
module lif_homeo_neuron #(
  parameter int NUM_LEVELS = 4,
  parameter int MEM_W      = 16,
  parameter logic [NUM_LEVELS*MEM_W-1:0] FIRE_LVLS =
    {16'sd500, 16'sd400, 16'sd300, 16'sd200},
  parameter int POT_GAP    = 40,
  parameter int DEP_GAP    = 80,
  parameter int INIT_LVL   = 1,
  parameter int LEAK_SH    = 3,
  parameter int REFRAC     = 3,
  parameter int TR_W       = 12,
  parameter int TR_SH      = 4,
  parameter int TR_INC     = 256,
  parameter int TARGET     = 512,
  parameter int MARGIN     = 128,
  localparam int IDX_W     = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [MEM_W-1:0] syn_in,
  output logic                    spike,
  output logic signed [MEM_W-1:0] membrane,
  output logic [TR_W-1:0]         activity,
  output logic [IDX_W-1:0]        level,
  output logic signed [MEM_W-1:0] thr_fire,
  output logic signed [MEM_W-1:0] thr_pot,
  output logic signed [MEM_W-1:0] thr_dep
);
  logic fire_now;

  lifh_membrane #(
    .MEM_W(MEM_W), .LEAK_SH(LEAK_SH), .REFRAC(REFRAC), .RST_LVL('0)
  ) u_mem (
    .clk(clk), .rst(rst), .syn_in(syn_in), .thr_fire(thr_fire),
    .fire_now(fire_now), .spike(spike), .mem(membrane)
  );

  lifh_trace #(
    .TR_W(TR_W), .TR_SH(TR_SH), .TR_INC(TR_INC)
  ) u_trace (
    .clk(clk), .rst(rst), .fire_now(fire_now), .act(activity)
  );

  lifh_thresh #(
    .NUM_LEVELS(NUM_LEVELS), .MEM_W(MEM_W), .FIRE_LVLS(FIRE_LVLS),
    .POT_GAP(POT_GAP), .DEP_GAP(DEP_GAP), .INIT_LVL(INIT_LVL),
    .TR_W(TR_W), .TARGET(TARGET), .MARGIN(MARGIN)
  ) u_thresh (
    .clk(clk), .rst(rst), .fire_now(fire_now), .act(activity),
    .level(level), .thr_fire(thr_fire), .thr_pot(thr_pot), .thr_dep(thr_dep)
  );
endmodule

// File: tb/lif_homeo_neuron_bench.sv
module lif_homeo_neuron_bench;
  localparam int MW = 16;
  localparam int TW = 12;

  typedef struct {
    int v; int rf; int tr; int idx; int fire;
  } mstate_t;

  typedef struct {
    int spk; int v; int tr; int idx; int tf; int tp; int td;
  } obs_t;

  typedef struct { obs_t a; obs_t b; } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [MW-1:0] syn_in = '0;

  logic spk_a, spk_b;
  logic signed [MW-1:0] mem_a, mem_b, tf_a, tp_a, td_a, tf_b, tp_b, td_b;
  logic [TW-1:0] act_a, act_b;
  logic [1:0] lvl_a;
  logic [0:0] lvl_b;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  item_t sb[$];
  mstate_t ma, mb;

  always #10 clk = ~clk;

  lif_homeo_neuron u_lif_homeo_neuron (
    .clk(clk), .rst(rst), .syn_in(syn_in), .spike(spk_a), .membrane(mem_a),
    .activity(act_a), .level(lvl_a), .thr_fire(tf_a), .thr_pot(tp_a), .thr_dep(td_a)
  );

  // R9: binary threshold variant
  lif_homeo_neuron #(
    .NUM_LEVELS(2), .FIRE_LVLS({16'sd450, 16'sd250}), .INIT_LVL(0)
  ) u_lif_homeo_neuron_bin (
    .clk(clk), .rst(rst), .syn_in(syn_in), .spike(spk_b), .membrane(mem_b),
    .activity(act_b), .level(lvl_b), .thr_fire(tf_b), .thr_pot(tp_b), .thr_dep(td_b)
  );

  function automatic int tab_a(int i);
    return 200 + 100 * i;
  endfunction
  function automatic int tab_b(int i);
    return (i == 0) ? 250 : 450;
  endfunction

  function automatic mstate_t adv(mstate_t s, int x, int thr, int nlev);
    mstate_t n = s;
    int nxt, dec;
    n.fire = 0;
    if (s.rf > 0) begin
      n.rf = s.rf - 1;
      n.v = 0;
    end else begin
      nxt = s.v - (s.v >>> 3) + x;
      if (nxt > 32767) nxt = 32767;
      if (nxt < -32768) nxt = -32768;
      if (nxt > thr) begin
        n.fire = 1; n.v = 0; n.rf = 3;
      end else n.v = nxt;
    end
    dec = s.tr - (s.tr >> 4);
    if (n.fire == 1) dec = dec + 256;
    if (dec > 4095) dec = 4095;
    n.tr = dec;
    if (n.fire == 1) begin
      if (s.tr > 640 && s.idx < nlev - 1) n.idx = s.idx + 1;
      else if (s.tr < 384 && s.idx > 0)   n.idx = s.idx - 1;
    end
    return n;
  endfunction

  function automatic obs_t mk(mstate_t s, int tf);
    obs_t o;
    o.spk = s.fire; o.v = s.v; o.tr = s.tr; o.idx = s.idx;
    o.tf = tf; o.tp = tf - 40; o.td = tf - 80;
    return o;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // driver: apply one step and push the expected outputs
  task automatic step(int x);
    item_t it;
    @(negedge clk);
    syn_in = MW'(x);
    ma = adv(ma, x, tab_a(ma.idx), 4);
    mb = adv(mb, x, tab_b(mb.idx), 2);
    it.a = mk(ma, tab_a(ma.idx));
    it.b = mk(mb, tab_b(mb.idx));
    sb.push_back(it);
  endtask

  task automatic drain();
    wait (sb.size() == 0);
    #1;
  endtask

  // monitor: compare just after each active edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      item_t e;
      e = sb.pop_front();
      chk("R3", "A spike", int'(spk_a), e.a.spk);
      chk("R2,R4,R10", "A membrane", int'(mem_a), e.a.v);
      chk("R5", "A activity", int'(act_a), e.a.tr);
      chk("R6", "A level", int'(lvl_a), e.a.idx);
      chk("R8", "A thr_fire", int'(tf_a), e.a.tf);
      chk("R8", "A thr_pot", int'(tp_a), e.a.tp);
      chk("R8", "A thr_dep", int'(td_a), e.a.td);
      chk("R9", "B spike", int'(spk_b), e.b.spk);
      chk("R9", "B membrane", int'(mem_b), e.b.v);
      chk("R9", "B activity", int'(act_b), e.b.tr);
      chk("R9", "B level", int'(lvl_b), e.b.idx);
      chk("R9", "B thr_fire", int'(tf_b), e.b.tf);
      chk("R9", "B thr_pot", int'(tp_b), e.b.tp);
      chk("R9", "B thr_dep", int'(td_b), e.b.td);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    ma = '{v:0, rf:0, tr:0, idx:1, fire:0};
    mb = '{v:0, rf:0, tr:0, idx:0, fire:0};
    repeat (4) @(posedge clk);
    #5;
    // R1: reset state
    chk("R1", "A spike", int'(spk_a), 0);
    chk("R1", "A membrane", int'(mem_a), 0);
    chk("R1", "A activity", int'(act_a), 0);
    chk("R1", "A level", int'(lvl_a), 1);
    chk("R1", "A thr_fire", int'(tf_a), 300);
    chk("R1", "A thr_dep", int'(td_a), 220);
    chk("R1", "B level", int'(lvl_b), 0);
    chk("R1", "B thr_fire", int'(tf_b), 250);
    @(negedge clk);
    rst = 1'b0;

    // R3: equal to threshold (A) must not fire; B fires
    step(300);
    for (int i = 0; i < 6; i++) step(0);   // R2 leak
    // R10: stacked negative full scale
    step(-32768);
    step(-32768);
    step(-32768);
    for (int i = 0; i < 30; i++) step(1000);
    // R4: large inputs inside refractory windows
    for (int i = 0; i < 20; i++) step(32767);
    // R7: dense firing drives level to the top
    for (int i = 0; i < 80; i++) step(32767);
    drain();
    chk("R7", "A level at top", int'(lvl_a), 3);
    chk("R7", "B level at top", int'(lvl_b), 1);
    // R6: seven-cycle trains around the dead band
    for (int r = 0; r < 14; r++) begin
      step(32767);
      for (int i = 0; i < 6; i++) step(0);
    end
    // R7: sparse lone spikes drive level to the bottom
    for (int r = 0; r < 8; r++) begin
      step(32767);
      for (int i = 0; i < 47; i++) step(0);
    end
    drain();
    chk("R7", "A level at bottom", int'(lvl_a), 0);
    chk("R7", "B level at bottom", int'(lvl_b), 0);
    chk("R8", "A thr_fire at bottom", int'(tf_a), 200);
    // mixed moderate pattern
    for (int i = 0; i < 60; i++) step((i % 5) * 70 - 40);
    drain();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule